// File: doc/BRIEF.md
# Chained-Counter Watchdog Timer

This block holds a small chain of down-counters behind a word-addressed register bus. One counter in the chain acts as the watchdog. When it runs out while it is linked to the reset path, the block raises a reset request and holds it until the block itself is reset. The counter in front of it is a helper. Any end-of-count event from the helper reloads the watchdog counter from its programmed timeout through a hardware path.

Software services the watchdog without stopping it. It loads the helper's reload value with zero and then turns the helper's enable bit off and back on. The helper finishes on the spot, and its end-of-count event restarts the watchdog from its full timeout. At no time is the watchdog disabled, so there is never a gap in which a hung system would go unnoticed. Every counter divides the input tick by a programmable prescaler. Writes to the count registers fill a shadow reload value only. The running count takes that value when the counter is started or triggered.

Top module: `chained_wdt`

## Requirements
- R1: Counter n occupies byte offsets n*0x10 (control), n*0x10+4 (live count bits 31:0) and n*0x10+8 (live count bits 63:32). The link register sits at 0x20. Only word-aligned addresses hit a register. All other addresses read 0.
- R2: After reset every register, every live count and the reset request read 0.
- R3: The control word is laid out as bit 0 enable, bit 1 busy (read-only), bits 3:2 mode (0 single-shot, 3 event-restart), bits 7:4 trigger source (5 = end-of-count of the preceding counter) and bits 15:8 prescaler. A write to a count register changes only the shadow reload value, never the live count.
- R4: While busy and enabled, a counter decrements its live count once every P asserted ticks, where P is the prescaler (0 acts as 1). With tick low it holds. On reaching 0 it clears busy and emits one end-of-count event.
- R5: In a mode other than event-restart, an enable write that takes the enable bit from 0 to 1 loads the live count from the shadow and sets busy from the next cycle. With a shadow of 0 the counter does not go busy, and its end-of-count event occurs at the same edge.
- R6: A counter in event-restart mode with source 5 and enable set reloads its full shadow value on every end-of-count event of the preceding counter, including while it is already counting. Setting its enable bit alone does not start it.
- R7: A trigger event has no effect on a counter that is disabled or whose source field is not 5.
- R8: A write that clears the enable bit stops the counter at that edge. Busy clears, the live count keeps its value, and no end-of-count event is produced.
- R9: The reset request rises one cycle after the end-of-count event of counter 1, when link bit 1 is set and counter 1 is enabled in event-restart mode. It then stays high until reset.
- R10: With link bit 1 clear, including after 0 is written to the link register, an expiry of counter 1 does not raise the reset request.
- R11: A service write that enables counter 0 with a shadow of 0 restarts counter 1 two edges after the write edge is sampled. The new live count can be read after the second edge.
- R12: If counter 1's shadow is 0 when it is triggered, it expires at the reload edge, and the reset request follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable pulse fed to every prescaler |
| bus_addr_i | input | 6 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| wdog_rst_o | output | 1 | Sticky system reset request |

## Verification
A write takes effect at the edge that samples it. The live count and the busy flag can be read back right after that edge. The helper's end-of-count event is registered, so the watchdog counter reloads at the second edge after a service write. The reset request is registered once more and appears at the edge after the watchdog's own end-of-count. The bench keeps a behavioural model that steps on the same edges and compares read data and the reset request every cycle at the falling edge. Directed peeks are placed in the exact cycle each result is due, for example one cycle before and one cycle after a reload or a reset rise.

// File: rtl/cwdt_pkg.sv
package cwdt_pkg;

    localparam int unsigned BUS_W = 32;
    localparam int unsigned DIV_W = 8;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_RSV1   = 2'd1,
        MODE_RSV2   = 2'd2,
        MODE_EVENT  = 2'd3
    } cnt_mode_e;

    // trigger source code: end-of-count of the counter just before this one
    localparam logic [3:0] SRC_PREV = 4'd5;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [3:0]       src;
        cnt_mode_e        mode;
        logic             busy;
        logic             run;
    } cnt_ctrl_t;

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
    import cwdt_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_ctrl_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             trig_i,
    output cnt_ctrl_t        ctrl_o,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    localparam int unsigned HI_W = CNT_W - BUS_W;

    typedef struct packed {
        cnt_ctrl_t        ctrl;
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] count;
        logic [DIV_W-1:0] phase;
        logic             expire;
    } cnt_state_t;

    cnt_state_t q, d;
    cnt_ctrl_t  new_ctrl;
    logic [DIV_W-1:0] div_eff;
    logic start, retrig, stop;

    always_comb begin
        d        = q;
        d.expire = 1'b0;
        new_ctrl = cnt_ctrl_t'(wdata_i[15:0]);
        div_eff  = (q.ctrl.div == '0) ? DIV_W'(1) : q.ctrl.div;

        // prescaled decrement
        if (q.ctrl.busy && q.ctrl.run && tick_i) begin
            if (q.phase >= div_eff - DIV_W'(1)) begin
                d.phase = '0;
                if (q.count <= CNT_W'(1)) begin
                    d.count     = '0;
                    d.ctrl.busy = 1'b0;
                    d.expire    = 1'b1;
                end else begin
                    d.count = q.count - CNT_W'(1);
                end
            end else begin
                d.phase = q.phase + DIV_W'(1);
            end
        end

        // shadow reload value
        if (wr_lo_i) d.shadow[BUS_W-1:0]     = wdata_i;
        if (wr_hi_i) d.shadow[CNT_W-1:BUS_W] = wdata_i[HI_W-1:0];

        // control fields (busy is not writable)
        if (wr_ctrl_i) begin
            d.ctrl.run  = new_ctrl.run;
            d.ctrl.mode = new_ctrl.mode;
            d.ctrl.src  = new_ctrl.src;
            d.ctrl.div  = new_ctrl.div;
        end

        start  = wr_ctrl_i && new_ctrl.run && !q.ctrl.run && (new_ctrl.mode != MODE_EVENT);
        retrig = trig_i && q.ctrl.run && (q.ctrl.mode == MODE_EVENT) && (q.ctrl.src == SRC_PREV);
        stop   = wr_ctrl_i && !new_ctrl.run;

        if (start || retrig) begin
            d.count = q.shadow;
            d.phase = '0;
            if (q.shadow == '0) begin
                d.ctrl.busy = 1'b0;
                d.expire    = 1'b1;
            end else begin
                d.ctrl.busy = 1'b1;
                d.expire    = 1'b0;
            end
        end

        // disable wins over everything, freezes the count
        if (stop) begin
            d.ctrl.busy = 1'b0;
            d.expire    = 1'b0;
            d.phase     = '0;
            d.count     = q.count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl_o   = q.ctrl;
    assign count_o  = q.count;
    assign expire_o = q.expire;

endmodule

// File: rtl/wdt_regmap.sv
module wdt_regmap
    import cwdt_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned NUM_CNT = 2,
    parameter int unsigned CNT_W   = 64
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  cnt_ctrl_t         ctrl_i  [NUM_CNT],
    input  logic [CNT_W-1:0]  count_i [NUM_CNT],
    input  logic [NUM_CNT-1:0] link_i,
    output logic              wr_ctrl_o [NUM_CNT],
    output logic              wr_lo_o   [NUM_CNT],
    output logic              wr_hi_o   [NUM_CNT],
    output logic              wr_link_o,
    output logic [BUS_W-1:0]  rdata_o
);

    localparam int unsigned BLK_W = ADDR_W - 4;

    logic [BLK_W-1:0] blk;
    logic [1:0]       slot;
    logic             aligned;

    assign blk     = addr_i[ADDR_W-1:4];
    assign slot    = addr_i[3:2];
    assign aligned = (addr_i[1:0] == 2'b00);

    always_comb begin
        rdata_o   = '0;
        wr_link_o = wr_i && aligned && (blk == BLK_W'(NUM_CNT)) && (slot == 2'd0);
        if (aligned && (blk == BLK_W'(NUM_CNT)) && (slot == 2'd0))
            rdata_o = BUS_W'(link_i);
        for (int i = 0; i < NUM_CNT; i++) begin
            wr_ctrl_o[i] = wr_i && aligned && (blk == BLK_W'(i)) && (slot == 2'd0);
            wr_lo_o[i]   = wr_i && aligned && (blk == BLK_W'(i)) && (slot == 2'd1);
            wr_hi_o[i]   = wr_i && aligned && (blk == BLK_W'(i)) && (slot == 2'd2);
            if (aligned && (blk == BLK_W'(i))) begin
                case (slot)
                    2'd0:    rdata_o = BUS_W'(ctrl_i[i]);
                    2'd1:    rdata_o = count_i[i][BUS_W-1:0];
                    2'd2:    rdata_o = BUS_W'(count_i[i][CNT_W-1:BUS_W]);
                    default: rdata_o = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/chained_wdt.sv
module chained_wdt
    import cwdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 64,
    parameter int unsigned NUM_CNT  = 2,
    parameter int unsigned WDOG_IDX = 1,
    parameter int unsigned ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic              wdog_rst_o
);

    typedef struct packed {
        logic [NUM_CNT-1:0] link;
        logic               rst_req;
    } top_state_t;

    top_state_t q, d;

    cnt_ctrl_t        ctrl_w   [NUM_CNT];
    logic [CNT_W-1:0] count_w  [NUM_CNT];
    logic             expire_w [NUM_CNT];
    logic             wr_ctrl  [NUM_CNT];
    logic             wr_lo    [NUM_CNT];
    logic             wr_hi    [NUM_CNT];
    logic             wr_link;

    wdt_regmap #(
        .ADDR_W (ADDR_W),
        .NUM_CNT(NUM_CNT),
        .CNT_W  (CNT_W)
    ) u_regmap (
        .addr_i   (bus_addr_i),
        .wr_i     (bus_wr_i),
        .ctrl_i   (ctrl_w),
        .count_i  (count_w),
        .link_i   (q.link),
        .wr_ctrl_o(wr_ctrl),
        .wr_lo_o  (wr_lo),
        .wr_hi_o  (wr_hi),
        .wr_link_o(wr_link),
        .rdata_o  (bus_rdata_o)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic trig;
        if (g == 0) begin : g_head
            assign trig = 1'b0;
        end else begin : g_link
            assign trig = expire_w[g-1];
        end
        wdt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_i),
            .wr_ctrl_i(wr_ctrl[g]),
            .wr_lo_i  (wr_lo[g]),
            .wr_hi_i  (wr_hi[g]),
            .wdata_i  (bus_wdata_i),
            .trig_i   (trig),
            .ctrl_o   (ctrl_w[g]),
            .count_o  (count_w[g]),
            .expire_o (expire_w[g])
        );
    end

    always_comb begin
        d = q;
        if (wr_link) d.link = bus_wdata_i[NUM_CNT-1:0];
        if (expire_w[WDOG_IDX] && q.link[WDOG_IDX] && ctrl_w[WDOG_IDX].run
            && (ctrl_w[WDOG_IDX].mode == MODE_EVENT))
            d.rst_req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wdog_rst_o = q.rst_req;

endmodule

// File: rtl/wdt_chain_chk.sv
module wdt_chain_chk #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned WIDX   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              wdog_rst,
    input logic              exp_helper,
    input logic              exp_wd,
    input logic              busy_wd,
    input logic              run_wd,
    input logic [1:0]        mode_wd,
    input logic [3:0]        src_wd,
    input logic              link_wd
);

    logic wd_ctrl_wr;
    assign wd_ctrl_wr = bus_wr && (bus_addr == ADDR_W'(WIDX * 16));

    // R9
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> wdog_rst);

    // R9
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst) |-> $past(exp_wd && link_wd && run_wd && (mode_wd == 2'd3)));

    // R8
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_ctrl_wr && !bus_wdata[0]) |=> (!busy_wd && !exp_wd));

    // R6
    retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_helper && run_wd && (mode_wd == 2'd3) && (src_wd == 4'd5) && !wd_ctrl_wr)
        |=> (busy_wd || exp_wd));

    // R10
    no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_wd && !link_wd && !wdog_rst) |=> !wdog_rst);

    // R4
    exp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_wd |-> !busy_wd);

endmodule

bind chained_wdt wdt_chain_chk #(
    .ADDR_W(ADDR_W),
    .WIDX  (WDOG_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .wdog_rst  (wdog_rst_o),
    .exp_helper(expire_w[0]),
    .exp_wd    (expire_w[WDOG_IDX]),
    .busy_wd   (ctrl_w[WDOG_IDX].busy),
    .run_wd    (ctrl_w[WDOG_IDX].run),
    .mode_wd   (ctrl_w[WDOG_IDX].mode),
    .src_wd    (ctrl_w[WDOG_IDX].src),
    .link_wd   (q.link[WDOG_IDX])
);

// File: tb/tb_chained_wdt.sv
module tb_chained_wdt;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdog_rst;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    chained_wdt dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .bus_addr_i (bus_addr),
        .bus_wr_i   (bus_wr),
        .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata),
        .wdog_rst_o (wdog_rst)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    int          m_div [2], m_src [2], m_mode [2], m_ph [2];
    bit          m_en [2], m_act [2], m_exp [2];
    logic [63:0] m_cnt [2], m_shd [2];
    bit [1:0]    m_sel;
    bit          m_rst;

    int          n_div [2], n_src [2], n_mode [2], n_ph [2];
    bit          n_en [2], n_act [2], n_exp [2];
    logic [63:0] n_cnt [2], n_shd [2];
    bit [1:0]    n_sel;
    bit          n_rst;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_div[i] = 0; m_src[i] = 0; m_mode[i] = 0; m_ph[i] = 0;
                m_en[i] = 0; m_act[i] = 0; m_exp[i] = 0;
                m_cnt[i] = '0; m_shd[i] = '0;
            end
            m_sel = '0;
            m_rst = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                int  dv;
                bit  wc, go;
                n_div[i] = m_div[i]; n_src[i] = m_src[i]; n_mode[i] = m_mode[i];
                n_ph[i] = m_ph[i]; n_en[i] = m_en[i]; n_act[i] = m_act[i];
                n_exp[i] = 0; n_cnt[i] = m_cnt[i]; n_shd[i] = m_shd[i];
                if (m_act[i] && m_en[i] && tick) begin
                    dv = (m_div[i] == 0) ? 1 : m_div[i];
                    if (m_ph[i] + 1 >= dv) begin
                        n_ph[i] = 0;
                        if (m_cnt[i] <= 1) begin
                            n_cnt[i] = 0; n_act[i] = 0; n_exp[i] = 1;
                        end else n_cnt[i] = m_cnt[i] - 1;
                    end else n_ph[i] = m_ph[i] + 1;
                end
                wc = bus_wr && (bus_addr == 6'(i * 16));
                if (wc) begin
                    n_en[i]   = bus_wdata[0];
                    n_mode[i] = int'(bus_wdata[3:2]);
                    n_src[i]  = int'(bus_wdata[7:4]);
                    n_div[i]  = int'(bus_wdata[15:8]);
                end
                if (bus_wr && bus_addr == 6'(i * 16 + 4)) n_shd[i][31:0]  = bus_wdata;
                if (bus_wr && bus_addr == 6'(i * 16 + 8)) n_shd[i][63:32] = bus_wdata;
                go = (wc && bus_wdata[0] && !m_en[i] && bus_wdata[3:2] != 2'd3)
                  || (i == 1 && m_exp[0] && m_en[1] && m_mode[1] == 3 && m_src[1] == 5);
                if (go) begin
                    n_cnt[i] = m_shd[i]; n_ph[i] = 0;
                    if (m_shd[i] == 0) begin n_act[i] = 0; n_exp[i] = 1; end
                    else begin n_act[i] = 1; n_exp[i] = 0; end
                end
                if (wc && !bus_wdata[0]) begin
                    n_act[i] = 0; n_exp[i] = 0; n_ph[i] = 0; n_cnt[i] = m_cnt[i];
                end
            end
            n_sel = m_sel;
            if (bus_wr && bus_addr == 6'h20) n_sel = bus_wdata[1:0];
            n_rst = m_rst;
            if (m_exp[1] && m_sel[1] && m_en[1] && m_mode[1] == 3) n_rst = 1;
            for (int i = 0; i < 2; i++) begin
                m_div[i] = n_div[i]; m_src[i] = n_src[i]; m_mode[i] = n_mode[i];
                m_ph[i] = n_ph[i]; m_en[i] = n_en[i]; m_act[i] = n_act[i];
                m_exp[i] = n_exp[i]; m_cnt[i] = n_cnt[i]; m_shd[i] = n_shd[i];
            end
            m_sel = n_sel;
            m_rst = n_rst;
        end
    end

    function automatic logic [31:0] model_read(input logic [5:0] a);
        logic [31:0] r = '0;
        for (int i = 0; i < 2; i++) begin
            if (a == 6'(i * 16))
                r = {16'b0, 8'(m_div[i]), 4'(m_src[i]), 2'(m_mode[i]), m_act[i], m_en[i]};
            if (a == 6'(i * 16 + 4)) r = m_cnt[i][31:0];
            if (a == 6'(i * 16 + 8)) r = m_cnt[i][63:32];
        end
        if (a == 6'h20) r = {30'b0, m_sel};
        return r;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 model readback", 64'(bus_rdata), 64'(model_read(bus_addr)));
            check("R9 model reset request", 64'(wdog_rst), 64'(m_rst));
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [5:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic peek_rst(input bit exp, input string tag);
        #1;
        check(tag, 64'(wdog_rst), 64'(exp));
    endtask

    // restart the watchdog through the helper: enable off then on
    task automatic service();
        wr(6'h00, 32'h0000_0200);
        wr(6'h00, 32'h0000_0201);
    endtask

    task automatic finish_report();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_report();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R2 reset state
        peek(6'h00, 32'h0, "R2 ctrl0 after reset");
        peek(6'h14, 32'h0, "R2 count1 after reset");
        peek(6'h20, 32'h0, "R2 link after reset");
        peek_rst(1'b0, "R2 reset request after reset");

        // R1 / R3 layout and shadow-only count writes
        wr(6'h00, 32'h0000_0200);
        peek(6'h00, 32'h0000_0200, "R3 ctrl0 field readback");
        wr(6'h04, 32'd5);
        peek(6'h04, 32'h0, "R3 count write leaves live count");
        peek(6'h32, 32'h0, "R1 unaligned address reads 0");

        // R5 / R4 single-shot count with prescaler 2
        wr(6'h04, 32'd3);
        wr(6'h00, 32'h0000_0201);
        peek(6'h04, 32'd3, "R5 start loads shadow");
        peek(6'h00, 32'h0000_0203, "R5 busy after start");
        idle(2);
        peek(6'h04, 32'd2, "R4 one decrement per two ticks");
        tick = 1'b0;
        idle(4);
        peek(6'h04, 32'd2, "R4 holds without tick");
        tick = 1'b1;
        idle(4);
        peek(6'h04, 32'd0, "R4 reaches zero");
        peek(6'h00, 32'h0000_0201, "R4 busy cleared at end");

        // R6 / R11 helper restarts the watchdog counter
        wr(6'h00, 32'h0000_0200);
        wr(6'h04, 32'd0);
        wr(6'h14, 32'd20);
        wr(6'h18, 32'd0);
        wr(6'h10, 32'h0000_025D);
        peek(6'h10, 32'h0000_025D, "R6 enable alone does not start");
        peek(6'h14, 32'h0, "R6 no load without trigger");
        wr(6'h20, 32'd2);
        wr(6'h00, 32'h0000_0201);
        peek(6'h00, 32'h0000_0201, "R5 zero shadow never busy");
        peek(6'h14, 32'h0, "R11 not yet reloaded after one edge");
        idle(1);
        peek(6'h14, 32'd20, "R11 reloaded after two edges");
        peek(6'h10, 32'h0000_025F, "R11 watchdog busy");
        idle(10);
        peek(6'h14, 32'd15, "R4 watchdog counts down");
        service();
        idle(1);
        peek(6'h14, 32'd20, "R6 restart while counting");
        wr(6'h18, 32'd1);
        service();
        idle(1);
        peek(6'h18, 32'd1, "R1 high count word");
        peek(6'h14, 32'd20, "R1 low count word");

        // R8 disable freezes and stays quiet
        wr(6'h10, 32'h0000_025C);
        peek(6'h10, 32'h0000_025C, "R8 busy cleared on disable");
        idle(20);
        peek(6'h14, 32'd20, "R8 count frozen");
        peek_rst(1'b0, "R8 no expiry after disable");

        // R7 trigger ignored when disabled or wrong source
        service();
        idle(2);
        peek(6'h10, 32'h0000_025C, "R7 disabled counter ignores trigger");
        wr(6'h10, 32'h0000_020D);
        service();
        idle(2);
        peek(6'h10, 32'h0000_020D, "R7 wrong source ignores trigger");

        // R10 expiry without link
        wr(6'h20, 32'd0);
        wr(6'h18, 32'd0);
        wr(6'h14, 32'd2);
        wr(6'h10, 32'h0000_025C);
        wr(6'h10, 32'h0000_025D);
        service();
        idle(9);
        peek(6'h10, 32'h0000_025D, "R10 watchdog expired");
        peek_rst(1'b0, "R10 no reset without link");

        // R9 linked expiry raises sticky reset
        wr(6'h20, 32'd2);
        service();
        idle(4);
        peek_rst(1'b0, "R9 still counting");
        idle(1);
        peek_rst(1'b0, "R9 expiry edge, request not yet");
        idle(1);
        peek_rst(1'b1, "R9 request one edge after expiry");
        idle(10);
        peek_rst(1'b1, "R9 request held");
        service();
        idle(2);
        peek_rst(1'b1, "R9 service does not clear request");
        rst_n = 1'b0;
        peek_rst(1'b0, "R9 cleared by reset");
        idle(2);
        rst_n = 1'b1;

        // R12 zero timeout expires at once
        wr(6'h20, 32'd2);
        wr(6'h10, 32'h0000_025D);
        wr(6'h00, 32'h0000_0201);
        peek_rst(1'b0, "R12 after helper edge");
        idle(1);
        peek_rst(1'b0, "R12 at watchdog expiry edge");
        peek(6'h10, 32'h0000_025D, "R12 watchdog not busy");
        idle(1);
        peek_rst(1'b1, "R12 request follows expiry");

        idle(2);
        finish_report();
    end

endmodule